// File: doc/BRIEF.md
# Field Event Interrupt Controller

This block collects the field events of a video timing generator and turns them into one level interrupt for a host processor. A single-cycle pulse on the bottom-field input or the top-field input sets a sticky bit in a 16-bit status register. The bit stays set until software clears it. A 16-bit enable mask selects which status bits may raise the interrupt line.

Software uses a flat register port: a write strobe, an address and write data, with read data that follows the address at once. Status is cleared by writing ones to a dedicated clear address. No address writes the mask directly. Mask bits are turned on through one address and turned off through another, so each write touches only the bits written as one. A typical service routine reads the status, writes that value to the status clear address, and reads which field fired from the value it saved.

Top module: `fld_irq_ctrl`

## Requirements
- R1: After reset, status reads 0x0000, mask reads 0x0000 and the interrupt output is low.
- R2: A pulse on the bottom-field event input sets status bit 0 on the next clock edge. A pulse on the top-field event input sets status bit 1. Status is read at address 0x78.
- R3: A write to address 0x7C clears every status bit whose write-data bit is one. It leaves the other status bits unchanged.
- R4: A write to address 0x8C sets every mask bit whose write-data bit is one. A write to address 0x88 clears every mask bit whose write-data bit is one. Write-data bits that are zero leave the mask unchanged. A read of either address returns the current mask.
- R5: The interrupt output is high exactly when at least one status bit and the matching mask bit are both one.
- R6: When a status clear write and a new event hit the same status bit in the same cycle, the bit stays set.
- R7: Status bits 15:2 always read zero. Mask bits 15:2 store whatever is written to them through the set and clear addresses.
- R8: A write to the status read address 0x78 changes nothing. A write to an unmapped address changes nothing. A read of an unmapped address returns 0x0000.
- R9: Writing a previously read status value to address 0x7C clears exactly the bits that were set in that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_bot_i | input | 1 | Bottom-field event pulse |
| evt_top_i | input | 1 | Top-field event pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W (8) | Register byte address |
| reg_wdata_i | input | REG_W (16) | Register write data |
| reg_rdata_o | output | REG_W (16) | Read data for reg_addr_i, combinational |
| irq_o | output | 1 | Level interrupt request |

## Verification
The main corner is a clear write that hits a bit in the same cycle as a new event on it. If the clear were given priority, a field event would be lost and the bench would read status bit 0 as zero. The bench writes all ones to the reserved status bits and the mask-only addresses. A design that latched or cleared the wrong bits would show a stray status bit or a wrong mask value. Writes to the read-only status address and to an unmapped address must leave both registers unchanged. A decoder that matched addresses loosely would clear status or mask there. The bench also checks the interrupt with a set status bit whose mask bit is off. A design that ignored the mask would raise the interrupt in that case.

// File: rtl/fld_irq_pkg.sv
package fld_irq_pkg;
   // Field event bit positions in the status register
   localparam int unsigned EVT_BOT_BIT = 0;
   localparam int unsigned EVT_TOP_BIT = 1;
   localparam int unsigned NUM_EVT     = 2;

   // Register byte addresses
   localparam logic [7:0] ADR_STAT      = 8'h78;
   localparam logic [7:0] ADR_STAT_CLR  = 8'h7C;
   localparam logic [7:0] ADR_MASK_CLR  = 8'h88;
   localparam logic [7:0] ADR_MASK_SET  = 8'h8C;
endpackage

// File: rtl/fld_irq_status.sv
module fld_irq_status #(
   parameter int unsigned REG_W   = 16,
   parameter int unsigned NUM_EVT = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] evt_i,
   input  logic               clr_i,
   input  logic [REG_W-1:0]   clr_bits_i,
   output logic [REG_W-1:0]   stat_o
);
   generate
      if (NUM_EVT < 1 || NUM_EVT > REG_W) begin : g_bad_cfg
         $error("fld_irq_status: NUM_EVT must be within 1..REG_W");
      end
      for (genvar i = 0; i < REG_W; i++) begin : g_bit
         if (i < NUM_EVT) begin : g_live
            logic bit_q;
            always_ff @(posedge clk) begin
               if (!rst_n)
                  bit_q <= 1'b0;
               else if (evt_i[i])
                  bit_q <= 1'b1;       // a new event beats a clear in the same cycle
               else if (clr_i && clr_bits_i[i])
                  bit_q <= 1'b0;
            end
            assign stat_o[i] = bit_q;
         end else begin : g_rsvd
            assign stat_o[i] = 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/fld_irq_mask.sv
module fld_irq_mask #(
   parameter int unsigned REG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_i,
   input  logic             clr_i,
   input  logic [REG_W-1:0] bits_i,
   output logic [REG_W-1:0] mask_o
);
   logic [REG_W-1:0] mask_q;
   logic [REG_W-1:0] set_v;
   logic [REG_W-1:0] clr_v;

   always_comb begin
      set_v = set_i ? bits_i : '0;
      clr_v = clr_i ? bits_i : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         mask_q <= '0;
      else
         mask_q <= (mask_q & ~clr_v) | set_v;
   end

   assign mask_o = mask_q;
endmodule

// File: rtl/fld_irq_rdmux.sv
module fld_irq_rdmux #(
   parameter int unsigned REG_W  = 16,
   parameter int unsigned ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [REG_W-1:0]  stat_i,
   input  logic [REG_W-1:0]  mask_i,
   output logic [REG_W-1:0]  rdata_o
);
   import fld_irq_pkg::*;
   localparam logic [ADDR_W-1:0] A_ST  = ADDR_W'(ADR_STAT);
   localparam logic [ADDR_W-1:0] A_SC  = ADDR_W'(ADR_STAT_CLR);
   localparam logic [ADDR_W-1:0] A_MC  = ADDR_W'(ADR_MASK_CLR);
   localparam logic [ADDR_W-1:0] A_MS  = ADDR_W'(ADR_MASK_SET);

   always_comb begin
      if (addr_i == A_ST || addr_i == A_SC)
         rdata_o = stat_i;
      else if (addr_i == A_MC || addr_i == A_MS)
         rdata_o = mask_i;
      else
         rdata_o = '0;
   end
endmodule

// File: rtl/fld_irq_ctrl.sv
module fld_irq_ctrl #(
   parameter int unsigned REG_W  = 16,
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_bot_i,
   input  logic              evt_top_i,
   input  logic              reg_wr_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [REG_W-1:0]  reg_wdata_i,
   output logic [REG_W-1:0]  reg_rdata_o,
   output logic              irq_o
);
   import fld_irq_pkg::*;

   generate
      if (ADDR_W < 8) begin : g_bad_addr
         $error("fld_irq_ctrl: ADDR_W must be at least 8");
      end
      if (REG_W < NUM_EVT) begin : g_bad_width
         $error("fld_irq_ctrl: REG_W too small for the field events");
      end
   endgenerate

   localparam logic [ADDR_W-1:0] A_SC = ADDR_W'(ADR_STAT_CLR);
   localparam logic [ADDR_W-1:0] A_MC = ADDR_W'(ADR_MASK_CLR);
   localparam logic [ADDR_W-1:0] A_MS = ADDR_W'(ADR_MASK_SET);

   logic [NUM_EVT-1:0] evt_vec;
   logic               wr_stat_clr;
   logic               wr_mask_clr;
   logic               wr_mask_set;
   logic [REG_W-1:0]   stat_q;
   logic [REG_W-1:0]   mask_q;

   always_comb begin
      evt_vec              = '0;
      evt_vec[EVT_BOT_BIT] = evt_bot_i;
      evt_vec[EVT_TOP_BIT] = evt_top_i;
   end

   assign wr_stat_clr = reg_wr_i && (reg_addr_i == A_SC);
   assign wr_mask_clr = reg_wr_i && (reg_addr_i == A_MC);
   assign wr_mask_set = reg_wr_i && (reg_addr_i == A_MS);

   fld_irq_status #(.REG_W(REG_W), .NUM_EVT(NUM_EVT)) u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_i      (evt_vec),
      .clr_i      (wr_stat_clr),
      .clr_bits_i (reg_wdata_i),
      .stat_o     (stat_q)
   );

   fld_irq_mask #(.REG_W(REG_W)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (wr_mask_set),
      .clr_i  (wr_mask_clr),
      .bits_i (reg_wdata_i),
      .mask_o (mask_q)
   );

   fld_irq_rdmux #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_rdmux (
      .addr_i  (reg_addr_i),
      .stat_i  (stat_q),
      .mask_i  (mask_q),
      .rdata_o (reg_rdata_o)
   );

   assign irq_o = |(stat_q & mask_q);
endmodule

// File: rtl/fld_irq_ctrl_chk.sv
module fld_irq_ctrl_chk #(
   parameter int unsigned REG_W  = 16,
   parameter int unsigned ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              evt_bot_i,
   input logic              evt_top_i,
   input logic              reg_wr_i,
   input logic [ADDR_W-1:0] reg_addr_i,
   input logic [REG_W-1:0]  reg_wdata_i,
   input logic              irq_o,
   input logic [REG_W-1:0]  stat_q,
   input logic [REG_W-1:0]  mask_q
);
   import fld_irq_pkg::*;
   localparam logic [ADDR_W-1:0] A_SC = ADDR_W'(ADR_STAT_CLR);
   localparam logic [ADDR_W-1:0] A_MC = ADDR_W'(ADR_MASK_CLR);
   localparam logic [ADDR_W-1:0] A_MS = ADDR_W'(ADR_MASK_SET);

   a_r2_bot_latch: assert property (@(posedge clk) disable iff (!rst_n)
      evt_bot_i |=> stat_q[EVT_BOT_BIT]);

   a_r2_top_latch: assert property (@(posedge clk) disable iff (!rst_n)
      evt_top_i |=> stat_q[EVT_TOP_BIT]);

   a_r3_w1c_bot: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_i && reg_addr_i == A_SC && reg_wdata_i[EVT_BOT_BIT] && !evt_bot_i)
      |=> !stat_q[EVT_BOT_BIT]);

   a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_i && reg_addr_i == A_SC && reg_wdata_i[EVT_TOP_BIT] && evt_top_i)
      |=> stat_q[EVT_TOP_BIT]);

   a_r4_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_i && reg_addr_i == A_MS)
      |=> ((mask_q & $past(reg_wdata_i)) == $past(reg_wdata_i)));

   a_r4_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_i && reg_addr_i == A_MC)
      |=> ((mask_q & $past(reg_wdata_i)) == '0));

   a_r8_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr_i && (reg_addr_i == A_MS || reg_addr_i == A_MC))
      |=> $stable(mask_q));

   a_r5_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> !irq_o);
endmodule

bind fld_irq_ctrl fld_irq_ctrl_chk #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .evt_bot_i   (evt_bot_i),
   .evt_top_i   (evt_top_i),
   .reg_wr_i    (reg_wr_i),
   .reg_addr_i  (reg_addr_i),
   .reg_wdata_i (reg_wdata_i),
   .irq_o       (irq_o),
   .stat_q      (stat_q),
   .mask_q      (mask_q)
);

// File: tb/fld_irq_ctrl_bench.sv
module fld_irq_ctrl_bench;
   localparam int REG_W  = 16;
   localparam int ADDR_W = 8;
   localparam int NVEC   = 12;

   typedef struct packed {
      logic        wr;
      logic [7:0]  addr;
      logic [15:0] wdata;
      logic        evb;
      logic        evt;
      logic [15:0] est;
      logic [15:0] emk;
      logic        eirq;
   } vec_t;

   // Cumulative sequence: each row is applied for one clock, then status, mask and irq are checked.
   localparam vec_t TBL [NVEC] = '{
      '{1'b0, 8'h00, 16'h0000, 1'b1, 1'b0, 16'h0001, 16'h0000, 1'b0}, // R2 bottom
      '{1'b0, 8'h00, 16'h0000, 1'b0, 1'b1, 16'h0003, 16'h0000, 1'b0}, // R2 top, R5 masked
      '{1'b1, 8'h8C, 16'h0001, 1'b0, 1'b0, 16'h0003, 16'h0001, 1'b1}, // R4 set, R5
      '{1'b1, 8'h7C, 16'h0002, 1'b0, 1'b0, 16'h0001, 16'h0001, 1'b1}, // R3 partial clear
      '{1'b1, 8'h88, 16'h0001, 1'b0, 1'b0, 16'h0001, 16'h0000, 1'b0}, // R4 clr, R5
      '{1'b1, 8'h8C, 16'hFFFC, 1'b0, 1'b0, 16'h0001, 16'hFFFC, 1'b0}, // R7 reserved mask
      '{1'b1, 8'h7C, 16'hFFFF, 1'b1, 1'b0, 16'h0001, 16'hFFFC, 1'b0}, // R6 event wins
      '{1'b1, 8'h78, 16'hFFFF, 1'b0, 1'b0, 16'h0001, 16'hFFFC, 1'b0}, // R8 read-only
      '{1'b1, 8'h8C, 16'h0003, 1'b0, 1'b1, 16'h0003, 16'hFFFF, 1'b1}, // R4 set, R2
      '{1'b1, 8'h88, 16'hFFFF, 1'b0, 1'b0, 16'h0003, 16'h0000, 1'b0}, // R4 clr all
      '{1'b1, 8'h7C, 16'h0003, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0}, // R9 write-back
      '{1'b1, 8'h40, 16'hFFFF, 1'b1, 1'b0, 16'h0001, 16'h0000, 1'b0}  // R8 unmapped, R7
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              evt_bot_i = 1'b0;
   logic              evt_top_i = 1'b0;
   logic              reg_wr_i = 1'b0;
   logic [ADDR_W-1:0] reg_addr_i = '0;
   logic [REG_W-1:0]  reg_wdata_i = '0;
   logic [REG_W-1:0]  reg_rdata_o;
   logic              irq_o;

   int n_chk = 0;
   int n_bad = 0;
   logic done = 1'b0;

   always #5 clk = ~clk;

   fld_irq_ctrl #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_fld_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .evt_bot_i(evt_bot_i), .evt_top_i(evt_top_i),
      .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
      .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [7:0] a, output logic [15:0] d);
      reg_addr_i = a;
      #1;
      d = reg_rdata_o;
   endtask

   // Drive one cycle at the falling edge; inputs return to idle right after the rising edge.
   task automatic step(input logic wr, input logic [7:0] a, input logic [15:0] wd,
                       input logic eb, input logic et);
      @(negedge clk);
      reg_wr_i = wr; reg_addr_i = a; reg_wdata_i = wd;
      evt_bot_i = eb; evt_top_i = et;
      @(posedge clk);
      #1;
      reg_wr_i = 1'b0; evt_bot_i = 1'b0; evt_top_i = 1'b0; reg_wdata_i = '0;
   endtask

   initial begin
      logic [15:0] d;
      logic [15:0] saved;
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      rd(8'h78, d); check("R1 status", d, 16'h0000);
      rd(8'h8C, d); check("R1 mask", d, 16'h0000);
      check("R1 irq", {15'd0, irq_o}, 16'h0000);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         step(TBL[i].wr, TBL[i].addr, TBL[i].wdata, TBL[i].evb, TBL[i].evt);
         rd(8'h78, d); check($sformatf("vec%0d status (R2 R3 R6 R7 R8 R9)", i), d, TBL[i].est);
         rd(8'h8C, d); check($sformatf("vec%0d mask (R4 R7 R8)", i), d, TBL[i].emk);
         check($sformatf("vec%0d irq (R5)", i), {15'd0, irq_o}, {15'd0, TBL[i].eirq});
      end

      // R4: the mask clear address reads back the mask too
      step(1'b1, 8'h8C, 16'hA5A4, 1'b0, 1'b0);
      rd(8'h88, d); check("R4 read at clear addr", d, 16'hA5A4);
      // R8 unmapped read returns zero
      rd(8'h40, d); check("R8 unmapped read", d, 16'h0000);
      // R3 status also readable at the clear address; R9 write back what was read
      step(1'b0, 8'h00, 16'h0000, 1'b0, 1'b1);
      rd(8'h7C, d); check("R3 status at clear addr", d, 16'h0003);
      saved = d;
      step(1'b1, 8'h7C, saved, 1'b0, 1'b0);
      rd(8'h78, d); check("R9 write-back clears read bits", d, 16'h0000);
      // R6 top bit: event and clear together keep the bit
      step(1'b1, 8'h7C, 16'hFFFF, 1'b0, 1'b1);
      rd(8'h78, d); check("R6 top event wins", d, 16'h0002);
      // R5 irq follows the mask even when status is already set
      step(1'b1, 8'h8C, 16'h0002, 1'b0, 1'b0);
      check("R5 irq on unmask", {15'd0, irq_o}, 16'h0001);
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 20000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
      end
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule